// File: doc/BRIEF.md
# Biphase Mark Line Decoder

This block takes a single self-clocking serial line that carries clock and data together in biphase mark code and turns it back into a stream of data bits. The line has already been sliced to a digital level. A local clock that runs eight times faster than the bit rate samples it. Every bit cell begins with a line transition. A cell holds a 1 when a second transition falls near its middle, and a 0 when it has none. The level of the line therefore carries no information, and a stream decodes the same way whichever level it starts from.

The input passes through a synchronizer, and each transition is then classified against a phase counter. The counter restarts on every boundary transition, so a stream whose cells drift a little longer or shorter stays aligned. The block reports each decoded bit with a one-cycle strobe. Two faults raise a one-cycle error pulse: a boundary that fails to arrive in time, and a transition where none may occur. A lock flag shows that the decoder has seen enough consecutive good cells to trust its output.

Top module: `bmd_decoder`

## Requirements
- R1: While reset is held and after its release with the line idle, `bit_stb`, `bit_val`, `locked` and `line_err` are all 0.
- R2: A cell with a transition inside its mid window decodes as 1, and a cell without one decodes as 0. Each cell produces exactly one `bit_stb` pulse, lasting one cycle, with `bit_val` valid in that cycle. The pulse follows the boundary transition that closes the cell.
- R3: The decoded bits depend only on where transitions fall, not on line polarity. The same cell pattern decodes identically whether the line starts low or high.
- R4: Phase is counted in samples since the last boundary. With OVERSAMPLE=8, a boundary is accepted at a phase of 6 to 11 samples, and a mid-cell transition at a phase of 3 to 5 samples. Cells of 7, 9 and 11 samples therefore decode correctly.
- R5: When aligned, if no boundary arrives before the phase reaches 12 samples (1.5 cells), `line_err` pulses for one cycle, alignment is lost and `locked` drops. A boundary arriving at phase 12 is too late.
- R6: A transition at a phase below the mid window, or a second transition inside the mid window, raises a one-cycle `line_err`, loses alignment and clears `locked`.
- R7: `locked` rises in the same cycle as the 16th consecutive `bit_stb` after reset or after the last error. It stays high until an error.
- R8: `bit_stb` and `line_err` are never high in the same cycle, and `bit_stb` is never high in two consecutive cycles.
- R9: The first transition after reset or after an error only sets alignment. It produces no strobe, and no timeout is reported while the decoder is unaligned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock, 8x the bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 1 | Sliced serial line, asynchronous to clk |
| bit_stb | output | 1 | One-cycle pulse per decoded cell |
| bit_val | output | 1 | Decoded bit, valid while bit_stb is high |
| locked | output | 1 | High after 16 consecutive good cells |
| line_err | output | 1 | One-cycle pulse on a missing or misplaced transition |

## Verification
Constant runs of zeros and ones check that the decoder recognises both the absence and the presence of a mid-cell transition. An alternating pattern and a pseudo-random stream show that the decision is made cell by cell, with no carry-over between cells. The same odd-transition pattern is sent twice in a row, so the second copy starts at the opposite line level; this separates polarity independence from level sensing. Cells of 7, 9 and 11 samples test the acceptance windows. A 12-sample cell and a glitch right after a boundary must each produce exactly one error, with lock dropping; a decoder that ignores timing faults fails these cases.

// File: rtl/bmd_pkg.sv
package bmd_pkg;
    // Verdict the cell timer gives on each sample cycle.
    typedef enum logic [1:0] {
        CELL_IDLE  = 2'd0,
        CELL_DONE  = 2'd1,
        CELL_FAULT = 2'd2
    } cell_verdict_e;
endpackage

// File: rtl/bmd_sampler.sv
module bmd_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic edge_o
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    // chain_q[SYNC_STAGES-1] is the synchronised sample, chain_q[SYNC_STAGES] the previous one
    logic [CHAIN_W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[CHAIN_W-2:0], line_in};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign edge_o = chain_q[SYNC_STAGES] ^ chain_q[SYNC_STAGES-1];
endmodule

// File: rtl/bmd_cell_timer.sv
module bmd_cell_timer
    import bmd_pkg::*;
#(
    parameter int OVERSAMPLE = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          edge_i,
    output cell_verdict_e verdict_o,
    output logic          cell_bit_o
);
    localparam int MID_LO  = OVERSAMPLE / 2 - OVERSAMPLE / 8;
    localparam int MID_HI  = OVERSAMPLE / 2 + OVERSAMPLE / 8;
    localparam int BND_LO  = OVERSAMPLE - OVERSAMPLE / 4;
    localparam int TIMEOUT = OVERSAMPLE + OVERSAMPLE / 2;
    localparam int PW      = $clog2(TIMEOUT + 1);

    localparam logic [PW-1:0] MID_LO_C  = PW'(MID_LO);
    localparam logic [PW-1:0] MID_HI_C  = PW'(MID_HI);
    localparam logic [PW-1:0] BND_LO_C  = PW'(BND_LO);
    localparam logic [PW-1:0] TIMEOUT_C = PW'(TIMEOUT);
    localparam logic [PW-1:0] ONE_C     = PW'(1);

    typedef struct packed {
        logic          aligned;
        logic          mid_seen;
        logic [PW-1:0] phase;
    } timer_t;

    timer_t        st_d, st_q;
    cell_verdict_e verdict;
    logic          cell_bit;
    logic          in_mid;
    logic          timed_out;

    always_comb begin
        st_d      = st_q;
        verdict   = CELL_IDLE;
        cell_bit  = st_q.mid_seen;
        in_mid    = (st_q.phase >= MID_LO_C) && (st_q.phase <= MID_HI_C);
        timed_out = st_q.aligned && (st_q.phase >= TIMEOUT_C);

        if (!st_q.aligned) begin
            if (edge_i) begin
                st_d.aligned  = 1'b1;
                st_d.mid_seen = 1'b0;
                st_d.phase    = ONE_C;
            end else if (st_q.phase < TIMEOUT_C) begin
                st_d.phase = st_q.phase + ONE_C;
            end
        end else if (timed_out) begin
            verdict       = CELL_FAULT;
            st_d.aligned  = 1'b0;
            st_d.mid_seen = 1'b0;
        end else if (edge_i) begin
            if (st_q.phase >= BND_LO_C) begin
                verdict       = CELL_DONE;
                st_d.mid_seen = 1'b0;
                st_d.phase    = ONE_C;
            end else if (in_mid && !st_q.mid_seen) begin
                st_d.mid_seen = 1'b1;
                st_d.phase    = st_q.phase + ONE_C;
            end else begin
                verdict       = CELL_FAULT;
                st_d.aligned  = 1'b0;
                st_d.mid_seen = 1'b0;
            end
        end else begin
            st_d.phase = st_q.phase + ONE_C;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{aligned: 1'b0, mid_seen: 1'b0, phase: '0};
        else        st_q <= st_d;
    end

    assign verdict_o  = verdict;
    assign cell_bit_o = cell_bit;

    // Phase never runs past the timeout while aligned
    p_phase_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.aligned |-> st_q.phase <= TIMEOUT_C);

    // Losing alignment only happens through a fault
    p_unalign_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.aligned && !st_d.aligned) |-> verdict == CELL_FAULT);

    // Unaligned timer never reports a fault or a finished cell
    p_unaligned_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.aligned |-> verdict == CELL_IDLE);
endmodule

// File: rtl/bmd_lock.sv
module bmd_lock
    import bmd_pkg::*;
#(
    parameter int LOCK_CELLS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  cell_verdict_e verdict_i,
    output logic          locked_o
);
    localparam int CW = $clog2(LOCK_CELLS + 1);
    localparam logic [CW-1:0] LOCK_C = CW'(LOCK_CELLS);

    typedef struct packed {
        logic [CW-1:0] count;
        logic          locked;
    } lock_t;

    lock_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (verdict_i == CELL_FAULT) begin
            st_d.count  = '0;
            st_d.locked = 1'b0;
        end else if (verdict_i == CELL_DONE && st_q.count < LOCK_C) begin
            st_d.count = st_q.count + CW'(1);
        end
        if (st_d.count == LOCK_C) st_d.locked = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{count: '0, locked: 1'b0};
        else        st_q <= st_d;
    end

    assign locked_o = st_q.locked;

    p_count_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= LOCK_C);

    p_lock_needs_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.locked |-> st_q.count == LOCK_C);
endmodule

// File: rtl/bmd_decoder.sv
module bmd_decoder
    import bmd_pkg::*;
#(
    parameter int OVERSAMPLE  = 8,
    parameter int SYNC_STAGES = 2,
    parameter int LOCK_CELLS  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic bit_stb,
    output logic bit_val,
    output logic locked,
    output logic line_err
);
    typedef struct packed {
        logic stb;
        logic val;
        logic err;
    } out_t;

    logic          edge_w;
    cell_verdict_e verdict_w;
    logic          cell_bit_w;
    out_t          out_d, out_q;

    bmd_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_in(line_in),
        .edge_o (edge_w)
    );

    bmd_cell_timer #(.OVERSAMPLE(OVERSAMPLE)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .edge_i    (edge_w),
        .verdict_o (verdict_w),
        .cell_bit_o(cell_bit_w)
    );

    bmd_lock #(.LOCK_CELLS(LOCK_CELLS)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .verdict_i(verdict_w),
        .locked_o (locked)
    );

    always_comb begin
        out_d     = '0;
        out_d.stb = (verdict_w == CELL_DONE);
        out_d.val = (verdict_w == CELL_DONE) && cell_bit_w;
        out_d.err = (verdict_w == CELL_FAULT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign bit_stb  = out_q.stb;
    assign bit_val  = out_q.val;
    assign line_err = out_q.err;

    p_err_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        line_err |=> !line_err);

    p_err_unlocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        line_err |-> !locked);

    p_stb_excl_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(bit_stb && line_err));

    p_stb_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |=> !bit_stb);

    p_lock_on_stb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> bit_stb);

    p_val_only_stb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_val |-> bit_stb);
endmodule

// File: tb/tb_bmd_decoder.sv
module tb_bmd_decoder;
    localparam int LOCK_N = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_in = 1'b0;
    logic bit_stb, bit_val, locked, line_err;

    int checks = 0;
    int errors = 0;
    int err_seen = 0;
    int stb_run = 0;
    bit finished = 1'b0;
    logic expq[$];

    always #4 clk = ~clk;

    bmd_decoder dut (
        .clk(clk), .rst_n(rst_n), .line_in(line_in),
        .bit_stb(bit_stb), .bit_val(bit_val), .locked(locked), .line_err(line_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: scoreboard pops expected bits, tracks lock
    always @(negedge clk) begin
        if (rst_n) begin
            if (bit_stb) begin
                stb_run++;
                if (expq.size() == 0) begin
                    check(1'b0, "R2 unexpected strobe", 1, 0);
                end else begin
                    logic e;
                    e = expq.pop_front();
                    check(bit_val == e, "R2 bit value", int'(bit_val), int'(e));
                end
                check(locked == (stb_run >= LOCK_N), "R7 lock after cells",
                      int'(locked), int'(stb_run >= LOCK_N));
                check(!line_err, "R8 strobe with error", int'(line_err), 0);
            end
            if (line_err) begin
                err_seen++;
                stb_run = 0;
                check(!locked, "R5 lock dropped on error", int'(locked), 0);
            end
        end
    end

    task automatic send_cell(input logic b, input int len, input bit push);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (i == 0) line_in = ~line_in;
            else if (b && i == len / 2) line_in = ~line_in;
        end
        if (push) expq.push_back(b);
    endtask

    task automatic close_and_idle();
        @(negedge clk);
        line_in = ~line_in;
        repeat (30) @(negedge clk);
    endtask

    task automatic expect_end(input string req, input int err_before, input int nerr);
        check(expq.size() == 0, {req, " all cells decoded"}, expq.size(), 0);
        expq.delete();
        check(err_seen - err_before == nerr, {req, " error count"}, err_seen - err_before, nerr);
        check(!locked, {req, " unlocked at end"}, int'(locked), 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int e0;
        logic [15:0] lfsr;
        logic [7:0] pat;
        int stb_count;

        repeat (4) @(negedge clk);
        // R1: reset state
        check(!bit_stb && !bit_val && !locked && !line_err, "R1 reset outputs",
              int'({bit_stb, bit_val, locked, line_err}), 0);
        rst_n = 1'b1;
        stb_count = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (bit_stb || line_err) stb_count++;
        end
        check(stb_count == 0 && !locked, "R1 idle after reset", stb_count, 0);

        // R2 R7 R5: alternating pattern, lock, then timeout
        e0 = err_seen;
        for (int i = 0; i < 20; i++) send_cell(1'(i % 2), 8, 1'b1);
        check(locked, "R7 locked after 19 cells", int'(locked), 1);
        close_and_idle();
        expect_end("R5 alternating", e0, 1);

        // R2: all zeros
        e0 = err_seen;
        for (int i = 0; i < 18; i++) send_cell(1'b0, 8, 1'b1);
        close_and_idle();
        expect_end("R2 zeros", e0, 1);

        // R2: all ones
        e0 = err_seen;
        for (int i = 0; i < 18; i++) send_cell(1'b1, 8, 1'b1);
        close_and_idle();
        expect_end("R2 ones", e0, 1);

        // R2: pseudo-random
        e0 = err_seen;
        lfsr = 16'hACE1;
        for (int i = 0; i < 40; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            send_cell(lfsr[0], 8, 1'b1);
        end
        close_and_idle();
        expect_end("R2 random", e0, 1);

        // R3: same pattern twice, second starts at opposite level
        pat = 8'b1011_0010;
        for (int rep = 0; rep < 2; rep++) begin
            logic start_lvl;
            start_lvl = line_in;
            e0 = err_seen;
            for (int i = 0; i < 8; i++) send_cell(pat[7-i], 8, 1'b1);
            close_and_idle();
            expect_end("R3 polarity", e0, 1);
            check(line_in != start_lvl, "R3 level flipped", int'(line_in), int'(~start_lvl));
        end

        // R4: drifting cell lengths 7, 9, 11
        e0 = err_seen;
        for (int i = 0; i < 24; i++) send_cell(1'(i % 3 == 1), 7 + 2 * (i % 3), 1'b1);
        check(locked, "R4 locked with drift", int'(locked), 1);
        close_and_idle();
        expect_end("R4 drift", e0, 1);

        // R5: a 12-sample cell is too late
        e0 = err_seen;
        for (int i = 0; i < 4; i++) send_cell(1'b1, 8, 1'b1);
        send_cell(1'b0, 12, 1'b0);
        close_and_idle();
        expect_end("R5 late boundary", e0, 1);

        // R6 R9: glitch right after a boundary
        e0 = err_seen;
        for (int i = 0; i < 5; i++) send_cell(1'(i % 2), 8, 1'b1);
        @(negedge clk); line_in = ~line_in;
        @(negedge clk); line_in = ~line_in;
        repeat (30) @(negedge clk);
        expect_end("R6 glitch", e0, 1);

        // R9: a lone transition only aligns; the following timeout is the only event
        e0 = err_seen;
        stb_count = stb_run;
        close_and_idle();
        check(stb_run == stb_count, "R9 no strobe on first edge", stb_run, stb_count);
        check(err_seen - e0 == 1, "R9 single error", err_seen - e0, 1);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule